// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

This block is a 3-bit state machine that steps through a fixed, non-binary ring of five codes (000, 010, 011, 101, 110, and back to 000) each time its count enable is high. The three codes that lie outside the ring (001, 100, 111) are not left undefined. The same minimized next-state equations give each of them a recovery path, so the counter reaches the ring from any power-up value within two enabled clocks.

The state bits are named C (bit 2), B (bit 1) and A (bit 0). The next state is C' = A, B' = ~B | (~A & ~C), A' = B & ~C. A combinational flag reports whether the present code is a ring member. A synchronous, active-low reset clears the state to 000. A synchronous load port places any 3-bit code into the state register, so that each recovery path can be started on purpose.

Top module: `seq5_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes 000 after that edge, whatever `en`, `ld` and `ld_code` are.
- R2: With `rst_n` high, `ld` low and `en` high, each clock moves the state one step along 000 → 010 → 011 → 101 → 110 → 000.
- R3: With `rst_n` high, `ld` low and `en` low, the state keeps its value across the clock edge.
- R4: With `rst_n` high and `ld` high, the state takes the value of `ld_code` at the clock edge, whether `en` is high or low.
- R5: From code 001, one enabled clock leads to 110.
- R6: From code 100, one enabled clock leads to 010.
- R7: From code 111, one enabled clock leads to 100. No clock ever leads into 111.
- R8: `valid` is 1 when the state is 000, 010, 011, 101 or 110, and 0 when it is 001, 100 or 111. It follows the state with no added cycle.
- R9: Starting from any of the eight codes, the state is a ring member after at most two enabled clocks, and it stays in the ring while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low, clears state to 000 |
| en | input | 1 | Count enable; low holds the state |
| ld | input | 1 | Synchronous load strobe, outranks `en` |
| ld_code | input | 3 | Code placed in the state by `ld` (bit 2 = C, bit 0 = A) |
| state | output | 3 | Present code {C,B,A} |
| valid | output | 1 | High while the state is a ring member |

## Verification
The hardest states to reach from the ports are the three codes off the ring: the counter never enters them while counting or after reset. The bench therefore uses the load port to place each of the eight codes in turn. It then gives exactly two enabled clocks and checks the first recovery step of each unused code against its stated target. The code 111 needs both clocks, because its path runs through 100.

// File: rtl/seq5_pkg.sv
// Package: shared widths, bit positions and ring codes for the
// five-state sequence counter. Assumes a 3-bit state ordered {C,B,A}.
package seq5_pkg;
    localparam int unsigned CODE_W   = 3;
    localparam int unsigned NUM_LOOP = 5;
    localparam int unsigned NUM_CODE = 1 << CODE_W;

    // Bit positions of the named state bits
    localparam int unsigned BIT_A = 0;
    localparam int unsigned BIT_B = 1;
    localparam int unsigned BIT_C = 2;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_ZERO = 3'b000;

    // Members of the counting ring, in ring order
    localparam code_t LOOP_TAB [NUM_LOOP] = '{
        3'b000, 3'b010, 3'b011, 3'b101, 3'b110
    };
endpackage

// File: rtl/seq5_next.sv
// Module: next-state function of the counter.
// Purely combinational. It implements the three minimized equations,
// which also give each unused code its recovery target.
// Assumes the input code is ordered {C,B,A}.
module seq5_next
    import seq5_pkg::*;
(
    input  code_t cur,
    output code_t nxt
);
    logic a_bit, b_bit, c_bit;

    // Split the present code into its named bits
    always_comb begin
        a_bit = cur[BIT_A];
        b_bit = cur[BIT_B];
        c_bit = cur[BIT_C];
    end

    // Evaluate the next-state equations
    always_comb begin
        nxt        = CODE_ZERO;
        nxt[BIT_C] = a_bit;
        nxt[BIT_B] = ~b_bit | (~a_bit & ~c_bit);
        nxt[BIT_A] = b_bit & ~c_bit;
    end
endmodule

// File: rtl/seq5_valid.sv
// Module: ring-membership decoder.
// Compares the code with each entry of the ring table and ORs the hits.
// Combinational, so the flag has no latency relative to the state.
module seq5_valid
    import seq5_pkg::*;
(
    input  code_t cur,
    output logic  in_loop
);
    logic [NUM_LOOP-1:0] hit;

    // One comparator per ring member
    for (genvar i = 0; i < NUM_LOOP; i++) begin : g_cmp
        assign hit[i] = (cur == LOOP_TAB[i]);
    end

    // Any hit marks a ring member
    always_comb begin
        in_loop = |hit;
    end
endmodule

// File: rtl/seq5_reg.sv
// Module: state register with priority reset > load > enable > hold.
// Reset is synchronous and active low. Assumes the next-state value
// and the ring flag come from the neighbouring combinational blocks.
module seq5_reg
    import seq5_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  ld,
    input  code_t ld_code,
    input  code_t nxt,
    input  logic  in_loop,
    output code_t cur
);
    code_t cur_q;

    // Update the state once per clock by priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= CODE_ZERO;
        end else if (ld) begin
            cur_q <= ld_code;
        end else if (en) begin
            cur_q <= nxt;
        end
    end

    assign cur = cur_q;

    // R1: reset clears the state
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_q == CODE_ZERO));

    // R3: no load and no enable keep the state
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !en) |=> $stable(cur_q));

    // R4: load takes the presented code
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cur_q == $past(ld_code)));

    // R9: a ring member stays in the ring while counting
    p_stay_in_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld && in_loop) |=> in_loop);

    // R9: an unused code reaches the ring or the one-step waypoint 100
    p_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld && !in_loop) |=> (in_loop || cur_q == 3'b100));

    // R7: counting never lands on 111
    p_no_111_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld) |=> (cur_q != 3'b111));
endmodule

// File: rtl/seq5_counter.sv
// Module: top of the self-starting five-state sequence counter.
// Joins the next-state function, the ring decoder and the state
// register. The state is exported as {C,B,A}.
module seq5_counter
    import seq5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ld,
    input  logic [CODE_W-1:0] ld_code,
    output logic [CODE_W-1:0] state,
    output logic              valid
);
    code_t cur_w;
    code_t nxt_w;
    logic  in_loop_w;

    seq5_next u_next (
        .cur (cur_w),
        .nxt (nxt_w)
    );

    seq5_valid u_valid (
        .cur     (cur_w),
        .in_loop (in_loop_w)
    );

    seq5_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ld      (ld),
        .ld_code (ld_code),
        .nxt     (nxt_w),
        .in_loop (in_loop_w),
        .cur     (cur_w)
    );

    // Drive the outputs from the internal nets
    always_comb begin
        state = cur_w;
        valid = in_loop_w;
    end
endmodule

// File: tb/seq5_counter_test.sv
`timescale 1ns/1ps
module seq5_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       ld = 1'b0;
    logic [2:0] ld_code = 3'b000;
    logic [2:0] state;
    logic       valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [2:0] model_q;
    bit         model_live = 1'b0;

    always #5 clk = ~clk;

    seq5_counter uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .ld      (ld),
        .ld_code (ld_code),
        .state   (state),
        .valid   (valid)
    );

    // Successor table taken from requirements R2, R5, R6, R7
    function automatic logic [2:0] ref_step(input logic [2:0] s);
        case (s)
            3'b000: return 3'b010;
            3'b010: return 3'b011;
            3'b011: return 3'b101;
            3'b101: return 3'b110;
            3'b110: return 3'b000;
            3'b001: return 3'b110;
            3'b100: return 3'b010;
            default: return 3'b100;
        endcase
    endfunction

    // Ring membership taken from requirement R8
    function automatic logic ref_valid(input logic [2:0] s);
        return (s == 3'b000) || (s == 3'b010) || (s == 3'b011) ||
               (s == 3'b101) || (s == 3'b110);
    endfunction

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) model_q <= 3'b000;
        else if (ld) model_q <= ld_code;
        else if (en) model_q <= ref_step(model_q);
        if (!rst_n) model_live <= 1'b1;
    end

    task automatic check(input bit ok, input string tag,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock, then compare outputs with the reference
    task automatic tick;
        @(posedge clk);
        #1;
        if (model_live) begin
            check(state === model_q, "R2 state vs model", state, model_q);
            check(valid === ref_valid(model_q), "R8 valid vs model", valid, ref_valid(model_q));
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] seq_exp;

        // R1: reset state
        rst_n = 1'b0; en = 1'b1; ld = 1'b0;
        tick; tick;
        check(state === 3'b000, "R1 reset value", state, 0);
        check(valid === 1'b1, "R8 valid after reset", valid, 1);

        // R2: ring order over more than two laps
        rst_n = 1'b1; en = 1'b1;
        seq_exp = 3'b000;
        for (int i = 0; i < 12; i++) begin
            tick;
            seq_exp = ref_step(seq_exp);
            check(state === seq_exp, "R2 ring step", state, seq_exp);
        end

        // R3: hold while disabled
        en = 1'b0;
        seq_exp = state;
        for (int i = 0; i < 3; i++) begin
            tick;
            check(state === seq_exp, "R3 hold", state, seq_exp);
        end

        // R4, R5, R6, R7, R8, R9: preload every code, then two enabled clocks
        for (int c = 0; c < 8; c++) begin
            en = 1'b0; ld = 1'b1; ld_code = 3'(c);
            tick;
            check(state === 3'(c), "R4 load", state, c);
            check(valid === ref_valid(3'(c)), "R8 valid decode", valid, ref_valid(3'(c)));
            ld = 1'b0; en = 1'b1;
            tick;
            if (c == 1) check(state === 3'b110, "R5 001 exit", state, 6);
            if (c == 4) check(state === 3'b010, "R6 100 exit", state, 2);
            if (c == 7) check(state === 3'b100, "R7 111 exit", state, 4);
            check(state !== 3'b111, "R7 never 111", state, 0);
            tick;
            check(valid === 1'b1, "R9 in ring after two clocks", valid, 1);
        end

        // R4: load outranks enable
        en = 1'b1; ld = 1'b1; ld_code = 3'b101;
        tick;
        check(state === 3'b101, "R4 load over enable", state, 5);

        // R1: reset outranks load and enable
        rst_n = 1'b0; ld = 1'b1; ld_code = 3'b111; en = 1'b1;
        tick;
        check(state === 3'b000, "R1 reset over load", state, 0);
        rst_n = 1'b1; ld = 1'b0; en = 1'b1;
        tick;
        check(state === 3'b010, "R2 first step after reset", state, 2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule